// File: doc/BRIEF.md
# Receive Descriptor Walker

This block walks a ring of receive buffer descriptors kept in system memory on behalf of an Ethernet-style MAC receive path. Each descriptor is two 32-bit words. Word 0 carries the buffer address in its upper bits, an ownership flag in bit 0 and a wrap flag in bit 1. Word 1 receives the number of bytes the MAC placed in the buffer. Every buffer holds 128 bytes, so a long frame uses several descriptors in turn. Software programs the ring base through a small register port and then enables reception.

When the receive datapath asks for a buffer, the walker reads word 0 of the current descriptor. If bit 0 is 0, the MAC owns the buffer and the walker offers its 128-byte aligned address. When the datapath reports the buffer full, the walker writes the byte count into word 1 and then writes word 0 back with bit 0 set, which returns the buffer to software. It then steps to the next descriptor. It goes back to the base after a descriptor with the wrap flag, or after the last of `RING_MAX` entries. A descriptor that software still owns halts the walk and raises a no-buffer flag.

The controller has six states. `S_IDLE` goes to `S_FETCH` when reception is on and a buffer is requested. `S_FETCH` waits for the read to complete. It then goes to `S_FILL` on a free descriptor, to `S_NOBUF` on a software-owned one, or to `S_IDLE` if reception was turned off. `S_FILL` goes to `S_PUT_LEN` on buffer-done, or to `S_IDLE` on disable. `S_PUT_LEN` goes to `S_PUT_OWN` when its write completes. `S_PUT_OWN` goes to `S_IDLE` when its write completes and steps the ring index at that point. `S_NOBUF` goes to `S_IDLE` once reception is disabled.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset, mem_req, buf_valid and rx_nobuf are 0, and both registers read 0: the queue base (cfg_sel=0) and the control register (cfg_sel=1, bit 0 = receive enable, bit 1 = transmit enable).
- R2: A write with cfg_sel=0 while both enables are 0 loads the queue base, with bits [2:0] forced to 0. A write with cfg_sel=1 is always accepted. cfg_rdata shows the selected register in the next cycle.
- R3: A queue base write made while receive enable or transmit enable is 1 is ignored, and the base keeps its value.
- R4: In S_IDLE, with receive enabled and buf_req high, the walker reads word 0 at base + 8*index.
- R5: If bit 0 of the fetched word 0 is 0, buf_valid rises with buf_addr equal to word 0 with bits [6:0] cleared. buf_valid then holds until buf_done, and no memory access occurs during that time.
- R6: If bit 0 of the fetched word 0 is 1, rx_nobuf rises. No buffer is granted and nothing is written to memory until receive enable is cleared.
- R7: After buf_done, the walker first writes buf_len, zero-extended, to word 1 (descriptor + 4). It then writes the fetched word 0 with bit 0 set back to word 0.
- R8: After that writeback, the index advances by one, or returns to 0 if bit 1 of word 0 was set.
- R9: With no wrap flag, the index returns to 0 after entry RING_MAX-1.
- R10: Clearing receive enable resets the index to 0, clears rx_nobuf, and withdraws a pending grant without any writeback.
- R11: While mem_req is high without mem_ack, mem_req, mem_we, mem_addr and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 queue base, 1 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| buf_req | input | 1 | Datapath asks for a buffer |
| buf_valid | output | 1 | A buffer is granted |
| buf_addr | output | 32 | Granted buffer address, 128-byte aligned |
| buf_done | input | 1 | Granted buffer is full or closed |
| buf_len | input | 8 | Bytes used in the buffer, 1 to 128 |
| rx_nobuf | output | 1 | Walk stopped on a software-owned descriptor |

## Verification
The bench builds the walker with RING_MAX=4 and BUF_BYTES=128. The small ring allows implicit wrap after the last entry to be reached within a few buffers. It also allows wrap-flag rings and full four-entry rings to be swept completely, with buffer lengths of 1 and 128 included. A memory model whose latency cycles through one to three wait states exercises the hold rule on every access, including back-to-back writebacks. The sweeps also cover a stop on a software-owned descriptor, a disable while a buffer is granted, and a change of queue base between rings.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_FILL,
        S_PUT_LEN,
        S_PUT_OWN,
        S_NOBUF
    } walk_state_t;

    localparam int OWN_BIT  = 0;
    localparam int WRAP_BIT = 1;
endpackage

// File: rtl/rxw_cfg_regs.sv
module rxw_cfg_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [DATA_W-1:0] qbase,
    output logic              rx_en,
    output logic              tx_en
);
    logic [DATA_W-4:0] base_q;
    logic              unused_bit2;

    assign unused_bit2 = cfg_wdata[2];
    assign qbase       = {base_q, 3'b000};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            rx_en  <= 1'b0;
            tx_en  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                rx_en <= cfg_wdata[0];
                tx_en <= cfg_wdata[1];
            end else if (!rx_en && !tx_en) begin
                base_q <= cfg_wdata[DATA_W-1:3];
            end
        end
    end

    always_comb begin
        if (cfg_sel) cfg_rdata = {{(DATA_W-2){1'b0}}, tx_en, rx_en};
        else         cfg_rdata = qbase;
    end

    a_r3_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en || tx_en) |=> $stable(qbase));
endmodule

// File: rtl/rxw_ring_index.sv
module rxw_ring_index #(
    parameter int RING_MAX = 1024,
    localparam int IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_MAX - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     idx <= '0;
        else if (clr)                   idx <= '0;
        else if (step) begin
            if (wrap || idx == LAST)    idx <= '0;
            else                        idx <= idx + 1'b1;
        end
    end

    a_r10_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx == '0));
    a_r9_index_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clr && (idx == LAST) |=> (idx == '0));
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rxw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RING_MAX  = 1024,
    parameter int BUF_BYTES = 128,
    localparam int BUF_SH   = $clog2(BUF_BYTES),
    localparam int LEN_W    = BUF_SH + 1,
    localparam int IDX_W    = (RING_MAX > 1) ? $clog2(RING_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              buf_req,
    output logic              buf_valid,
    output logic [DATA_W-1:0] buf_addr,
    input  logic              buf_done,
    input  logic [LEN_W-1:0]  buf_len,
    output logic              rx_nobuf
);
    walk_state_t       state, state_n;
    logic [DATA_W-1:0] qbase, desc_q, word0_q;
    logic [LEN_W-1:0]  len_q;
    logic [IDX_W-1:0]  idx;
    logic              rx_en, tx_en, step;

    rxw_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .qbase(qbase),
        .rx_en(rx_en), .tx_en(tx_en)
    );

    rxw_ring_index #(.RING_MAX(RING_MAX)) u_index (
        .clk(clk), .rst_n(rst_n), .clr(!rx_en), .step(step),
        .wrap(word0_q[WRAP_BIT]), .idx(idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // descriptor context captured along the walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q  <= '0;
            word0_q <= '0;
            len_q   <= '0;
        end else begin
            if (state == S_IDLE)
                desc_q <= qbase + (DATA_W'(idx) << 3);
            if (state == S_FETCH && mem_ack)
                word0_q <= mem_rdata;
            if (state == S_FILL && buf_done)
                len_q <= buf_len;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:    if (rx_en && buf_req) state_n = S_FETCH;
            S_FETCH:   if (mem_ack) begin
                           if (!rx_en)                     state_n = S_IDLE;
                           else if (mem_rdata[OWN_BIT])    state_n = S_NOBUF;
                           else                            state_n = S_FILL;
                       end
            S_FILL:    if (!rx_en)        state_n = S_IDLE;
                       else if (buf_done) state_n = S_PUT_LEN;
            S_PUT_LEN: if (mem_ack) state_n = S_PUT_OWN;
            S_PUT_OWN: if (mem_ack) state_n = S_IDLE;
            S_NOBUF:   if (!rx_en)  state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        step      = 1'b0;
        buf_valid = 1'b0;
        buf_addr  = {word0_q[DATA_W-1:BUF_SH], {BUF_SH{1'b0}}};
        rx_nobuf  = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_FETCH:   mem_req = 1'b1;
            S_FILL:    buf_valid = 1'b1;
            S_PUT_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + DATA_W'(4);
                mem_wdata = DATA_W'(len_q);
            end
            S_PUT_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = word0_q | DATA_W'(1);
                step      = mem_ack;
            end
            S_NOBUF:   rx_nobuf = 1'b1;
            default:   ;
        endcase
    end

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    a_r5_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> !mem_req);
    a_r6_nobuf_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nobuf |-> !mem_req && !buf_valid);
    a_r7_len_before_own: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUT_OWN) && ($past(state) != S_PUT_OWN) |-> ($past(state) == S_PUT_LEN));
    a_r10_nobuf_release: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nobuf && !rx_en |=> !rx_nobuf);
endmodule

// File: tb/test_rx_desc_walker.sv
module test_rx_desc_walker;
    localparam int RING = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        buf_req = 1'b0, buf_valid, buf_done = 1'b0, rx_nobuf;
    logic [31:0] buf_addr;
    logic [7:0]  buf_len = '0;

    logic [31:0] mem [64];
    logic        bw_en = 1'b0;
    logic [5:0]  bw_idx = '0;
    logic [31:0] bw_data = '0;
    int          lat_cnt = 0, lat_tgt = 0, wr_cnt = 0;
    logic [31:0] wr_prev = '0, wr_last = '0, rd_last = '0;
    int          checks = 0, errors = 0;
    logic [31:0] base = '0;

    always #5 clk = ~clk;

    rx_desc_walker #(.RING_MAX(RING), .BUF_BYTES(128)) i_rx_desc_walker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_req(buf_req),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_done(buf_done),
        .buf_len(buf_len), .rx_nobuf(rx_nobuf)
    );

    // memory model with 1..3 wait states, plus a bench-side write port
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (bw_en) mem[bw_idx] <= bw_data;
        if (mem_req && !mem_ack) begin
            if (lat_cnt >= lat_tgt) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                lat_tgt <= (lat_tgt + 1) % 3;
                if (mem_we) begin
                    mem[mem_addr[7:2]] <= mem_wdata;
                    wr_prev <= wr_last;
                    wr_last <= mem_addr;
                    wr_cnt  <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[7:2]];
                    rd_last   <= mem_addr;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // R11: request and its fields steady until acknowledged
    logic        p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [31:0] p_addr = '0, p_wdata = '0;
    always @(negedge clk) begin
        if (rst_n && p_req && !p_ack)
            chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata,
                "R11 hold", mem_addr, p_addr);
        p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
    end

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic bw(input logic [31:0] addr, input logic [31:0] d);
        @(negedge clk); bw_en = 1'b1; bw_idx = addr[7:2]; bw_data = d;
        @(negedge clk); bw_en = 1'b0;
    endtask

    function automatic logic [31:0] w0(input int k, input bit wrap);
        return 32'h0001_0000 + 32'(k) * 32'h1000 + 32'h7C + (wrap ? 32'h2 : 32'h0);
    endfunction

    task automatic arm(input int k, input bit wrap);
        bw(base + 32'(8 * k), w0(k, wrap));
        bw(base + 32'(8 * k) + 4, 32'h0);
    endtask

    task automatic serve(input int k, input bit wrap, input logic [7:0] len, input string rq);
        logic [31:0] d;
        int n, w;
        d = base + 32'(8 * k);
        @(negedge clk); buf_req = 1'b1;
        n = 0;
        while (!buf_valid && n < 60) begin @(negedge clk); n++; end
        buf_req = 1'b0;
        chk(buf_valid, {rq, " R5 grant"}, 32'(buf_valid), 32'h1);
        chk(rd_last == d, {rq, " R4 fetch addr"}, rd_last, d);
        chk(buf_addr == (w0(k, wrap) & ~32'h7F), {rq, " R5 buf_addr"}, buf_addr, w0(k, wrap) & ~32'h7F);
        repeat (3) @(negedge clk);
        chk(buf_valid && !mem_req, "R5 grant held", 32'(buf_valid), 32'h1);
        w = wr_cnt;
        buf_done = 1'b1; buf_len = len;
        @(negedge clk); buf_done = 1'b0;
        n = 0;
        while (wr_cnt < w + 2 && n < 60) begin @(negedge clk); n++; end
        chk(wr_prev == d + 4, {rq, " R7 first write word1"}, wr_prev, d + 4);
        chk(wr_last == d, {rq, " R7 second write word0"}, wr_last, d);
        chk(mem[(d + 4) >> 2 & 63] == 32'(len), {rq, " R7 length"}, mem[(d + 4) >> 2 & 63], 32'(len));
        chk(mem[d >> 2 & 63] == (w0(k, wrap) | 1), {rq, " R7 owner returned"}, mem[d >> 2 & 63], w0(k, wrap) | 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, w;
        logic [31:0] keep;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!mem_req && !buf_valid && !rx_nobuf, "R1 idle outputs", {29'b0, mem_req, buf_valid, rx_nobuf}, 32'h0);
        cfg_sel = 1'b0; @(negedge clk);
        chk(cfg_rdata == 0, "R1 base", cfg_rdata, 32'h0);
        cfg_sel = 1'b1; @(negedge clk);
        chk(cfg_rdata == 0, "R1 control", cfg_rdata, 32'h0);

        // R2 / R3
        cfg_write(1'b0, 32'h47);
        cfg_sel = 1'b0; @(negedge clk);
        chk(cfg_rdata == 32'h40, "R2 base low bits cleared", cfg_rdata, 32'h40);
        cfg_write(1'b1, 32'h2);
        cfg_sel = 1'b1; @(negedge clk);
        chk(cfg_rdata == 32'h2, "R2 control readback", cfg_rdata, 32'h2);
        cfg_write(1'b0, 32'h80);
        cfg_sel = 1'b0; @(negedge clk);
        chk(cfg_rdata == 32'h40, "R3 ignored with tx on", cfg_rdata, 32'h40);
        cfg_write(1'b1, 32'h1);
        cfg_write(1'b0, 32'hC0);
        cfg_sel = 1'b0; @(negedge clk);
        chk(cfg_rdata == 32'h40, "R3 ignored with rx on", cfg_rdata, 32'h40);
        cfg_write(1'b1, 32'h0);
        base = 32'h40;

        // R8: three-entry ring closed by the wrap flag, seven buffers
        cfg_write(1'b1, 32'h1);
        for (int b = 0; b < 7; b++) begin
            arm(b % 3, (b % 3) == 2);
            serve(b % 3, (b % 3) == 2, (b == 0) ? 8'd128 : 8'(1 + (b * 23) % 128), "R8 flag ring");
        end

        // R9: full ring without wrap flag, new base
        cfg_write(1'b1, 32'h0);
        cfg_write(1'b0, 32'h80);
        base = 32'h80;
        cfg_write(1'b1, 32'h1);
        for (int b = 0; b < 5; b++) begin
            arm(b % RING, 1'b0);
            serve(b % RING, 1'b0, (b == 4) ? 8'd1 : 8'(40 + b), "R9 implicit wrap");
        end

        // R6: entry 1 still owned by software
        bw(base + 8, w0(1, 1'b0) | 1);
        keep = mem[(base + 8) >> 2];
        w = wr_cnt;
        @(negedge clk); buf_req = 1'b1;
        n = 0;
        while (!rx_nobuf && n < 40) begin @(negedge clk); n++; end
        chk(rx_nobuf, "R6 flag raised", 32'(rx_nobuf), 32'h1);
        repeat (4) @(negedge clk);
        chk(!buf_valid, "R6 no grant", 32'(buf_valid), 32'h0);
        chk(wr_cnt == w, "R6 no write", 32'(wr_cnt), 32'(w));
        chk(mem[(base + 8) >> 2] == keep, "R6 descriptor untouched", mem[(base + 8) >> 2], keep);
        buf_req = 1'b0;

        // R10: disable clears flag and index
        cfg_write(1'b1, 32'h0);
        @(negedge clk);
        chk(!rx_nobuf, "R10 flag cleared", 32'(rx_nobuf), 32'h0);
        cfg_write(1'b1, 32'h1);
        arm(0, 1'b0);
        serve(0, 1'b0, 8'd77, "R10 restart at base");

        // R10: disable while granted
        arm(1, 1'b0);
        w = wr_cnt;
        @(negedge clk); buf_req = 1'b1;
        n = 0;
        while (!buf_valid && n < 40) begin @(negedge clk); n++; end
        buf_req = 1'b0;
        chk(buf_valid, "R10 grant before disable", 32'(buf_valid), 32'h1);
        cfg_write(1'b1, 32'h0);
        repeat (5) @(negedge clk);
        chk(!buf_valid, "R10 grant withdrawn", 32'(buf_valid), 32'h0);
        chk(wr_cnt == w, "R10 no writeback", 32'(wr_cnt), 32'(w));
        cfg_write(1'b1, 32'h1);
        arm(0, 1'b0);
        serve(0, 1'b0, 8'd128, "R10 index reset");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule